// File: doc/BRIEF.md
# Banked Data-Memory Address Generator

This block forms the data-RAM addresses for a small 8-bit microcontroller core. Each file-register operand is a 7-bit field taken from the instruction. The block turns that field into a 9-bit RAM address in one of two ways. In direct mode, two bank bits held from the status register are placed above the 7-bit field. If the field names the indirect data register (file 00h), the block uses indirect mode instead: a page bit from the status register is placed above an 8-bit pointer register. The block keeps its own copy of the pointer and of the status page and bank bits. It updates them whenever a write-back targets those files in any bank.

The read side and the write side of the RAM each have their own registered address bus. The block raises the output-enable one cycle after an operand fetch that reads a file. It raises the write strobe one cycle after a write-back to a file. An indirect access that points back at the indirect register itself is neutralised. Such a read enables no RAM and returns zero. Such a write produces no strobe. In the fetch address, a pointer or status update that is written back in the same cycle takes effect at once.

Top module: `dmem_addr_gen`

## Requirements
- R1: A fetch with a nonzero file field F gives, one cycle later, the read address {bank, F}. The bank is status bits 6:5.
- R2: A fetch with file field 00h gives, one cycle later, the read address {page, pointer}. The page is status bit 7.
- R3: `ram_oe` is high in the cycle after `fetch_phase` and `fetch_rd_file` are both high, and is low otherwise.
- R4: A write-back with `wb_phase` and `wb_to_file` both high pulses `ram_we` in the next cycle. The address follows the rules of R1 and R2, using the values held at the write-back, and `ram_wdata` equals `wb_data`.
- R5: An indirect fetch whose pointer has its low 7 bits all zero leaves `ram_oe` low, and `opnd_data` is 00h.
- R6: An indirect write-back whose pointer has its low 7 bits all zero produces no `ram_we` pulse and changes no held state.
- R7: A write-back whose effective address has low 7 bits 04h loads the pointer from `wb_data`. One whose low 7 bits are 03h loads the bank from bits 6:5 and the page from bit 7. Both hold in every bank and in both modes, and the RAM write still occurs.
- R8: A fetch in the same cycle as a pointer or status write-back uses the newly written value.
- R9: While `rst` is high, all registered outputs, the pointer, the bank and the page are zero.
- R10: `opnd_data` equals `ram_din` while `ram_oe` is high and is 00h otherwise. A fetch and a write to one address in the same cycle return the older contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_phase | input | 1 | Operand-fetch phase of the current instruction |
| fetch_rd_file | input | 1 | Current instruction reads a file register |
| fetch_file | input | 7 | File field of the fetching instruction |
| wb_phase | input | 1 | Write-back phase of the retiring instruction |
| wb_to_file | input | 1 | Retiring instruction's destination is a file register |
| wb_file | input | 7 | File field of the retiring instruction |
| wb_data | input | 8 | Result to write back |
| ram_din | input | 8 | Read data from the RAM |
| ram_raddr | output | 9 | RAM read address |
| ram_oe | output | 1 | RAM output enable |
| ram_waddr | output | 9 | RAM write address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| opnd_data | output | 8 | Operand to the core, zero when no RAM read is enabled |

## Verification
An operand fetch and the write-back of the previous instruction can occur in the same cycle. When that write-back changes the pointer or the status bits, the fetch address depends on which value wins. The bench provokes this by driving a pointer or status write-back together with an indirect or direct fetch. It expects the read address to be built from the new value, while the write address is built from the old one. A further case drives a same-cycle read and write to one address and expects the older data. Another writes a pointer whose low bits are zero while fetching through it, and expects the read to be suppressed.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  // File addresses decoded on the low file-field bits (mirrored in all banks)
  localparam int IND_FILE  = 0;
  localparam int STAT_FILE = 3;
  localparam int PTR_FILE  = 4;
  // Status field positions
  localparam int BANK_LSB  = 5;
  localparam int PAGE_POS  = 7;

  typedef enum logic [1:0] {
    EA_DIRECT   = 2'd0,
    EA_INDIRECT = 2'd1,
    EA_SELF     = 2'd2
  } ea_kind_e;
endpackage

// File: rtl/dmag_ea.sv
module dmag_ea #(
  parameter int FILE_W = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  localparam int ADDR_W = FILE_W + BANK_W
) (
  input  logic [FILE_W-1:0] file,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BANK_W-1:0] bank,
  input  logic              page,
  output logic [ADDR_W-1:0] addr,
  output dmag_pkg::ea_kind_e kind
);
  import dmag_pkg::*;

  logic is_ind;
  logic ptr_self;

  assign is_ind   = (file == FILE_W'(IND_FILE));
  assign ptr_self = (ptr[FILE_W-1:0] == FILE_W'(IND_FILE));

  generate
    if (PTR_W + 1 == ADDR_W) begin : g_exact
      always_comb begin
        addr = is_ind ? {page, ptr} : {bank, file};
      end
    end else begin : g_pad
      always_comb begin
        addr = is_ind ? ADDR_W'({page, ptr}) : {bank, file};
      end
    end
  endgenerate

  always_comb begin
    if (!is_ind)       kind = EA_DIRECT;
    else if (ptr_self) kind = EA_SELF;
    else               kind = EA_INDIRECT;
  end
endmodule

// File: rtl/dmag_regs.sv
module dmag_regs #(
  parameter int FILE_W = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FILE_W-1:0] wr_low,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              page_q,
  output logic [PTR_W-1:0]  ptr_nx,
  output logic [BANK_W-1:0] bank_nx,
  output logic              page_nx
);
  import dmag_pkg::*;

  logic ld_ptr;
  logic ld_stat;

  assign ld_ptr  = wr_en && (wr_low == FILE_W'(PTR_FILE));
  assign ld_stat = wr_en && (wr_low == FILE_W'(STAT_FILE));

  // Bypass: a fetch in the same cycle sees the value being written back
  always_comb begin
    ptr_nx  = ld_ptr  ? PTR_W'(wr_data)              : ptr_q;
    bank_nx = ld_stat ? wr_data[BANK_LSB +: BANK_W]  : bank_q;
    page_nx = ld_stat ? wr_data[PAGE_POS]            : page_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      bank_q <= '0;
      page_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_nx;
      bank_q <= bank_nx;
      page_q <= page_nx;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_ptr |=> $stable(ptr_q)); // R7
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_stat |=> ($stable(bank_q) && $stable(page_q))); // R7
endmodule

// File: rtl/dmag_port.sv
module dmag_port #(
  parameter int FILE_W = 7,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_req,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  dmag_pkg::ea_kind_e rd_kind,
  input  logic               wr_req,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  dmag_pkg::ea_kind_e wr_kind,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [ADDR_W-1:0]  ram_raddr,
  output logic               ram_oe,
  output logic [ADDR_W-1:0]  ram_waddr,
  output logic               ram_we,
  output logic [DATA_W-1:0]  ram_wdata
);
  import dmag_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_raddr <= '0;
      ram_oe    <= 1'b0;
      ram_waddr <= '0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
    end else begin
      ram_oe <= rd_req && (rd_kind != EA_SELF);
      ram_we <= wr_req && (wr_kind != EA_SELF);
      if (rd_req) ram_raddr <= rd_addr;
      if (wr_req) begin
        ram_waddr <= wr_addr;
        ram_wdata <= wr_data;
      end
    end
  end

  AST_OE_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
    ram_oe |-> $past(rd_req)); // R3
  AST_WE_FROM_WB: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(wr_req)); // R4
  AST_NO_SELF_READ: assert property (@(posedge clk) disable iff (rst)
    ram_oe |-> (ram_raddr[FILE_W-1:0] != FILE_W'(IND_FILE))); // R5
  AST_NO_SELF_WRITE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_waddr[FILE_W-1:0] != FILE_W'(IND_FILE))); // R6
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen #(
  parameter int DATA_W = 8,
  parameter int FILE_W = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  localparam int ADDR_W = FILE_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_phase,
  input  logic              fetch_rd_file,
  input  logic [FILE_W-1:0] fetch_file,
  input  logic              wb_phase,
  input  logic              wb_to_file,
  input  logic [FILE_W-1:0] wb_file,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [DATA_W-1:0] ram_din,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              ram_oe,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] opnd_data
);
  import dmag_pkg::*;

  logic               rd_req, wr_req;
  logic [PTR_W-1:0]   ptr_q, ptr_nx;
  logic [BANK_W-1:0]  bank_q, bank_nx;
  logic               page_q, page_nx;
  logic [ADDR_W-1:0]  rd_addr, wr_addr;
  ea_kind_e           rd_kind, wr_kind;

  assign rd_req = fetch_phase && fetch_rd_file;
  assign wr_req = wb_phase && wb_to_file;

  // Write side uses the held values
  dmag_ea #(.FILE_W(FILE_W), .BANK_W(BANK_W), .PTR_W(PTR_W)) u_ea_wr (
    .file(wb_file), .ptr(ptr_q), .bank(bank_q), .page(page_q),
    .addr(wr_addr), .kind(wr_kind)
  );

  dmag_regs #(.FILE_W(FILE_W), .BANK_W(BANK_W), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_req && (wr_kind != EA_SELF)),
    .wr_low(wr_addr[FILE_W-1:0]), .wr_data(wb_data),
    .ptr_q(ptr_q), .bank_q(bank_q), .page_q(page_q),
    .ptr_nx(ptr_nx), .bank_nx(bank_nx), .page_nx(page_nx)
  );

  // Read side uses the bypassed values
  dmag_ea #(.FILE_W(FILE_W), .BANK_W(BANK_W), .PTR_W(PTR_W)) u_ea_rd (
    .file(fetch_file), .ptr(ptr_nx), .bank(bank_nx), .page(page_nx),
    .addr(rd_addr), .kind(rd_kind)
  );

  dmag_port #(.FILE_W(FILE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_kind(rd_kind),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_kind(wr_kind), .wr_data(wb_data),
    .ram_raddr(ram_raddr), .ram_oe(ram_oe),
    .ram_waddr(ram_waddr), .ram_we(ram_we), .ram_wdata(ram_wdata)
  );

  assign opnd_data = ram_oe ? ram_din : '0;

  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rd_req && (rd_kind == EA_SELF)) |-> (opnd_data == '0)); // R5
endmodule

// File: tb/tb_dmem_addr_gen.sv
`timescale 1ns/1ps
module tb_dmem_addr_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fetch_phase = 0, fetch_rd_file = 0;
  logic [6:0] fetch_file = '0;
  logic       wb_phase = 0, wb_to_file = 0;
  logic [6:0] wb_file = '0;
  logic [7:0] wb_data = '0;
  logic [7:0] ram_din;
  logic [8:0] ram_raddr, ram_waddr;
  logic       ram_oe, ram_we;
  logic [7:0] ram_wdata, opnd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] ram   [512];
  logic [7:0] exp_m [512];
  logic [7:0] m_ptr = 0;
  logic [1:0] m_bank = 0;
  logic       m_page = 0;

  always #2 clk = ~clk;

  dmem_addr_gen dut (
    .clk(clk), .rst(rst),
    .fetch_phase(fetch_phase), .fetch_rd_file(fetch_rd_file), .fetch_file(fetch_file),
    .wb_phase(wb_phase), .wb_to_file(wb_to_file), .wb_file(wb_file), .wb_data(wb_data),
    .ram_din(ram_din), .ram_raddr(ram_raddr), .ram_oe(ram_oe),
    .ram_waddr(ram_waddr), .ram_we(ram_we), .ram_wdata(ram_wdata), .opnd_data(opnd_data)
  );

  // RAM model: asynchronous read, synchronous write
  assign ram_din = ram[ram_raddr];
  always @(posedge clk) if (ram_we) ram[ram_waddr] <= ram_wdata;

  function automatic logic [8:0] ea(input logic [6:0] f, input logic [7:0] p,
                                    input logic [1:0] b, input logic pg);
    return (f == 7'd0) ? {pg, p} : {b, f};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check outputs at the following negedge
  task automatic cyc(input bit rd, input logic [6:0] rf, input bit wb,
                     input logic [6:0] wf, input logic [7:0] wd, input string tag);
    logic [8:0] wea, rea;
    logic wself, rself, ewe, eoe;
    logic [7:0] nptr, edata;
    logic [1:0] nbank;
    logic npage;
    wea   = ea(wf, m_ptr, m_bank, m_page);
    wself = (wf == 0) && (m_ptr[6:0] == 0);
    ewe   = wb && !wself;
    nptr = m_ptr; nbank = m_bank; npage = m_page;
    if (ewe && wea[6:0] == 7'd4) nptr = wd;
    if (ewe && wea[6:0] == 7'd3) begin nbank = wd[6:5]; npage = wd[7]; end
    rea   = ea(rf, nptr, nbank, npage);
    rself = (rf == 0) && (nptr[6:0] == 0);
    eoe   = rd && !rself;
    edata = eoe ? exp_m[rea] : 8'h00;

    fetch_phase = rd; fetch_rd_file = rd; fetch_file = rf;
    wb_phase = wb; wb_to_file = wb; wb_file = wf; wb_data = wd;
    @(posedge clk);
    @(negedge clk);
    chk(rself ? "R5" : "R3", {tag, " ram_oe"}, ram_oe, eoe);
    if (eoe) chk(rf == 0 ? "R2 R7 R8" : "R1 R7 R8", {tag, " ram_raddr"}, ram_raddr, rea);
    chk(rself ? "R5" : "R10", {tag, " opnd_data"}, opnd_data, edata);
    chk(wself ? "R6" : "R4", {tag, " ram_we"}, ram_we, ewe);
    if (ewe) begin
      chk("R4", {tag, " ram_waddr"}, ram_waddr, wea);
      chk("R4", {tag, " ram_wdata"}, ram_wdata, wd);
      exp_m[wea] = wd;
    end
    m_ptr = nptr; m_bank = nbank; m_page = npage;
  endtask

  task automatic set_stat(input logic pg, input logic [1:0] b);
    cyc(0, 0, 1, 7'd3, {pg, b, 5'b0}, "R7 status");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin ram[i] = 8'h00; exp_m[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "ram_oe in reset", ram_oe, 0);
    chk("R9", "ram_we in reset", ram_we, 0);
    chk("R9", "ram_raddr in reset", ram_raddr, 0);
    chk("R9", "ram_waddr in reset", ram_waddr, 0);
    chk("R9", "opnd_data in reset", opnd_data, 0);
    rst = 1'b0;
    // Pointer reset to zero: indirect fetch is self-referencing
    cyc(1, 0, 0, 0, 0, "R9 ptr reset");

    // Fill every bank directly (status and pointer files skipped)
    for (int b = 0; b < 4; b++) begin
      set_stat(0, b[1:0]);
      for (int f = 1; f < 128; f++)
        if (f != 3 && f != 4)
          cyc(0, 0, 1, f[6:0], f[7:0] ^ {b[2:0], 5'b0} ^ 8'h5A, "R1 fill");
    end
    // Direct reads of every nonzero file in every bank
    for (int b = 0; b < 4; b++) begin
      set_stat(b[0], b[1:0]);
      for (int f = 1; f < 128; f++) cyc(1, f[6:0], 0, 0, 0, "R1 read");
    end
    // Indirect sweep of all pointer values on both pages
    for (int pg = 0; pg < 2; pg++) begin
      set_stat(pg[0], 2'd1);
      for (int p = 0; p < 256; p++) begin
        cyc(0, 0, 1, 7'd4, p[7:0], "R7 ptr");
        cyc(1, 0, 0, 0, 0, "R2 ind read");
        cyc(0, 0, 1, 0, ~p[7:0], "R6 ind write");
        if (p[6:0] == 7'd3) set_stat(pg[0], 2'd1);
        cyc(1, 0, 0, 0, 0, "R10 readback");
      end
    end
    // Same-cycle fetch and write-back
    set_stat(1, 2'd2);
    cyc(1, 0, 1, 7'd4, 8'h37, "R8 ptr bypass");
    cyc(1, 7'h20, 1, 7'd3, 8'h60, "R8 status bypass");
    cyc(1, 7'h21, 1, 7'h21, 8'hC3, "R10 same addr");
    cyc(1, 7'h21, 0, 0, 0, "R10 after write");
    cyc(1, 0, 1, 7'd4, 8'h80, "R8 self bypass");
    cyc(1, 0, 1, 0, 8'hEE, "R6 self write");
    cyc(0, 0, 0, 0, 0, "idle");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule